// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Condition Flags

This block is the arithmetic core of a small byte-wide processor. It holds an accumulator and a five-bit condition register. Each cycle in which the write enable is high, it applies one operation to the accumulator and an operand byte, or to a pair of 16-bit values. It then registers the new accumulator, the new flags and, for the wide add, the 16-bit sum. Instruction decode, memory access and decimal correction belong to the surrounding processor.

The operation set covers the following:
- add and add with the stored carry;
- subtract and compare, where compare changes the flags only;
- increment and decrement;
- bitwise AND, OR, XOR and complement;
- two kinds of one-bit rotate, each in both directions.

In the first rotate kind, the bit that leaves the accumulator wraps around and is also copied into carry. In the second kind, carry forms a ninth bit of the ring. Each operation changes only its own subset of the flags. The enclosing design relies on this when it tests carry or zero several operations later.

An asynchronous active-low reset clears every register. The block synchronises the release of the reset internally, over two clock edges.

Top module: `acc_flag_unit`

## Requirements
- R1: After reset, acc_o, flags_o and pair_sum_o are all zero.
- R2: While we_i is low, acc_o, flags_o and pair_sum_o hold their values whatever op_i and the data inputs carry.
- R3: ADD (op 1) loads the accumulator with acc+operand and ADC (op 2) with acc+operand+carry, modulo 256. Carry takes the carry out of bit 7.
- R4: SUB (op 3) loads acc-operand modulo 256 and sets carry when operand > acc, as a borrow. CMP (op 9) sets the flags exactly as SUB would but leaves the accumulator unchanged.
- R5: The auxiliary flag is the carry out of bit 3 of the low-nibble sum. For ADD/ADC this is the nibble sum of the addends. For SUB/CMP it is set when acc[3:0] >= operand[3:0]. For INC it is set when acc[3:0] was 0xF. For DEC it is set when acc[3:0] was nonzero.
- R6: Flag positions in flags_o are [4] sign, [3] zero, [2] auxiliary, [1] parity and [0] carry. On every arithmetic and bitwise result, sign is bit 7 of the result and zero is set when the result is 0x00. Parity is set when the result holds an even number of ones.
- R7: INC (op 4) and DEC (op 5) add or subtract one modulo 256. They update sign, zero, auxiliary and parity and leave carry unchanged.
- R8: AND (op 6), OR (op 7) and XOR (op 8) combine the accumulator with the operand bitwise and clear both carry and auxiliary.
- R9: Rotate-copy left (op 11) moves bit 7 into bit 0 and into carry. Rotate-copy right (op 12) moves bit 0 into bit 7 and into carry.
- R10: Rotate-through left (op 13) shifts the old carry into bit 0 and bit 7 into carry. Rotate-through right (op 14) shifts the old carry into bit 7 and bit 0 into carry. All four rotates change only carry among the flags.
- R11: LOAD (op 0) copies the operand into the accumulator and CMA (op 10) inverts it. Neither changes any flag.
- R12: PAIR (op 15) registers pair_a_i+pair_b_i modulo 65536 on pair_sum_o and sets carry to the carry out of bit 15. The accumulator and the other four flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 4 | Operation code |
| operand_i | input | 8 | Second operand byte |
| we_i | input | 1 | Apply op_i on this edge |
| pair_a_i | input | 16 | First wide addend |
| pair_b_i | input | 16 | Second wide addend |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 5 | {sign, zero, auxiliary, parity, carry} |
| pair_sum_o | output | 16 | Registered wide sum |

## Verification
The bench targets nibble boundaries such as 0x0F+0x01 and 0x10-0x01. A half-carry taken from the wrong bit, or with an inverted sense on subtract, shows up there as a wrong auxiliary flag. Wrap cases (0xFF+1, 0x00-1, FFFF+1 on the pair add) expose a carry or borrow of the wrong polarity. Chains that set carry, then run INC, CMA or a rotate, catch a design that disturbs flags it must leave alone, or a compare that writes the accumulator. Back-to-back rotates of both kinds, starting from known carry values, separate a ninth-bit ring from a wrap-around ring.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_LOAD = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADC  = 4'd2,
    OP_SUB  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_CMP  = 4'd9,
    OP_CMA  = 4'd10,
    OP_ROLC = 4'd11,
    OP_RORC = 4'd12,
    OP_ROLT = 4'd13,
    OP_RORT = 4'd14,
    OP_PAIR = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic half;
    logic par;
    logic cy;
  } flags_t;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         half_o
);
  localparam int H  = W / 2;
  localparam int HU = W - H;

  logic [H:0]  lo_sum;
  logic [HU:0] hi_sum;

  // split at the nibble boundary so the half carry is a real adder output
  assign lo_sum = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, cin_i};
  assign hi_sum = {1'b0, a_i[W-1:H]} + {1'b0, b_i[W-1:H]} + {{HU{1'b0}}, lo_sum[H]};

  assign sum_o  = {hi_sum[HU-1:0], lo_sum[H-1:0]};
  assign cout_o = hi_sum[HU];
  assign half_o = lo_sum[H];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    case (op_i)
      OP_AND:  begin res_o = a_i & b_i; cy_o = 1'b0; end
      OP_OR:   begin res_o = a_i | b_i; cy_o = 1'b0; end
      OP_XOR:  begin res_o = a_i ^ b_i; cy_o = 1'b0; end
      OP_CMA:  res_o = ~a_i;
      OP_ROLC: begin res_o = {a_i[W-2:0], a_i[W-1]}; cy_o = a_i[W-1]; end
      OP_RORC: begin res_o = {a_i[0], a_i[W-1:1]};   cy_o = a_i[0];   end
      OP_ROLT: begin res_o = {a_i[W-2:0], cy_i};     cy_o = a_i[W-1]; end
      OP_RORT: begin res_o = {cy_i, a_i[W-1:1]};     cy_o = a_i[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_flag_eval.sv
module alu8_flag_eval #(
  parameter int W = 8
) (
  input  logic [W-1:0] r_i,
  output logic         sign_o,
  output logic         zero_o,
  output logic         par_o
);
  assign sign_o = r_i[W-1];
  assign zero_o = (r_i == '0);
  assign par_o  = ~(^r_i);
endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      op_i,
  input  logic [W-1:0]    operand_i,
  input  logic            we_i,
  input  logic [2*W-1:0]  pair_a_i,
  input  logic [2*W-1:0]  pair_b_i,
  output logic [W-1:0]    acc_o,
  output logic [4:0]      flags_o,
  output logic [2*W-1:0]  pair_sum_o
);
  localparam int PW = 2 * W;

  // reset release synchroniser
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  alu_op_e       op;
  logic [W-1:0]  acc_q, acc_n;
  flags_t        flg_q, flg_n;
  logic [PW-1:0] psum_q, psum_n;

  assign op = alu_op_e'(op_i);

  // adder operand selection
  logic [W-1:0] add_b;
  logic         add_cin;
  always_comb begin
    add_b   = operand_i;
    add_cin = 1'b0;
    case (op)
      OP_ADC:         add_cin = flg_q.cy;
      OP_SUB, OP_CMP: begin add_b = ~operand_i; add_cin = 1'b1; end
      OP_INC:         begin add_b = '0;         add_cin = 1'b1; end
      OP_DEC:         add_b = '1;
      default: ;
    endcase
  end

  logic [W-1:0] sum;
  logic         cout, half;
  alu8_adder #(.W(W)) u_adder (
    .a_i(acc_q), .b_i(add_b), .cin_i(add_cin),
    .sum_o(sum), .cout_o(cout), .half_o(half)
  );

  logic [W-1:0] lres;
  logic         lcy;
  alu8_logic #(.W(W)) u_logic (
    .op_i(op), .a_i(acc_q), .b_i(operand_i), .cy_i(flg_q.cy),
    .res_o(lres), .cy_o(lcy)
  );

  logic         is_arith;
  logic [W-1:0] eval_in;
  logic         f_sign, f_zero, f_par;
  assign is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
                    (op == OP_CMP) || (op == OP_INC) || (op == OP_DEC);
  assign eval_in  = is_arith ? sum : lres;
  alu8_flag_eval #(.W(W)) u_flags (
    .r_i(eval_in), .sign_o(f_sign), .zero_o(f_zero), .par_o(f_par)
  );

  logic [PW:0] pair_full;
  assign pair_full = {1'b0, pair_a_i} + {1'b0, pair_b_i};

  // next state
  always_comb begin
    acc_n  = acc_q;
    flg_n  = flg_q;
    psum_n = psum_q;
    case (op)
      OP_LOAD: acc_n = operand_i;
      OP_ADD, OP_ADC: begin
        acc_n = sum;
        flg_n = '{sign: f_sign, zero: f_zero, half: half, par: f_par, cy: cout};
      end
      OP_SUB: begin
        acc_n = sum;
        flg_n = '{sign: f_sign, zero: f_zero, half: half, par: f_par, cy: ~cout};
      end
      OP_CMP:
        flg_n = '{sign: f_sign, zero: f_zero, half: half, par: f_par, cy: ~cout};
      OP_INC, OP_DEC: begin
        acc_n = sum;
        flg_n = '{sign: f_sign, zero: f_zero, half: half, par: f_par, cy: flg_q.cy};
      end
      OP_AND, OP_OR, OP_XOR: begin
        acc_n = lres;
        flg_n = '{sign: f_sign, zero: f_zero, half: 1'b0, par: f_par, cy: lcy};
      end
      OP_CMA: acc_n = lres;
      OP_ROLC, OP_RORC, OP_ROLT, OP_RORT: begin
        acc_n    = lres;
        flg_n.cy = lcy;
      end
      OP_PAIR: begin
        psum_n   = pair_full[PW-1:0];
        flg_n.cy = pair_full[PW];
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q  <= '0;
      flg_q  <= '0;
      psum_q <= '0;
    end else if (we_i) begin
      acc_q  <= acc_n;
      flg_q  <= flg_n;
      psum_q <= psum_n;
    end
  end

  assign acc_o      = acc_q;
  assign flags_o    = flg_q;
  assign pair_sum_o = psum_q;

  // assertions
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !we_i |=> $stable(acc_q) && $stable(flg_q) && $stable(psum_q));

  a_r4_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (we_i && op == OP_CMP) |=> $stable(acc_q));

  a_r11_cma_keeps_flags: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (we_i && (op == OP_CMA || op == OP_LOAD)) |=> $stable(flg_q));

  a_r12_pair_only_cy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (we_i && op == OP_PAIR) |=> $stable(acc_q) && $stable(flg_q[4:1]));

  a_r7_keep_cy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (we_i && (op == OP_INC || op == OP_DEC)) |=> $stable(flg_q.cy));

  a_r9_rolc_copy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (we_i && op == OP_ROLC) |=> (acc_q[0] == flg_q.cy));

  a_r6_zero_sign: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (we_i && (op == OP_ADD || op == OP_AND || op == OP_XOR)) |=>
      (flg_q.zero == (acc_q == '0)) && (flg_q.sign == acc_q[W-1]));
endmodule

// File: tb/tb_acc_flag_unit.sv
`timescale 1ns/1ps
module tb_acc_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op_i;
  logic [7:0]  operand_i;
  logic        we_i;
  logic [15:0] pair_a_i, pair_b_i;
  logic [7:0]  acc_o;
  logic [4:0]  flags_o;
  logic [15:0] pair_sum_o;

  always #2.5 clk = ~clk;

  acc_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .operand_i(operand_i), .we_i(we_i),
    .pair_a_i(pair_a_i), .pair_b_i(pair_b_i),
    .acc_o(acc_o), .flags_o(flags_o), .pair_sum_o(pair_sum_o)
  );

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state
  int m_acc, m_s, m_z, m_ac, m_p, m_cy, m_psum;

  function automatic string tag_of(int op, bit we);
    if (!we) return "R2";
    case (op)
      0, 10:        return "R11";
      1, 2:         return "R3 R5 R6";
      3, 9:         return "R4 R5 R6";
      4, 5:         return "R7 R5 R6";
      6, 7, 8:      return "R8 R6";
      11, 12:       return "R9";
      13, 14:       return "R10";
      default:      return "R12";
    endcase
  endfunction

  function automatic int even_ones(int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return (c % 2 == 0) ? 1 : 0;
  endfunction

  task automatic szp(int r);
    m_s = (r >> 7) & 1;
    m_z = (r == 0) ? 1 : 0;
    m_p = even_ones(r);
  endtask

  task automatic model(int op, int b, int pa, int pb);
    int r, t, nb;
    case (op)
      0: m_acc = b;
      1, 2: begin
        t = (op == 2) ? m_cy : 0;
        m_ac = (((m_acc & 15) + (b & 15) + t) > 15) ? 1 : 0;
        r = m_acc + b + t;
        m_cy = (r > 255) ? 1 : 0;
        m_acc = r & 255; szp(m_acc);
      end
      3, 9: begin
        m_ac = ((m_acc & 15) >= (b & 15)) ? 1 : 0;
        m_cy = (b > m_acc) ? 1 : 0;
        r = (m_acc - b) & 255; szp(r);
        if (op == 3) m_acc = r;
      end
      4: begin m_ac = ((m_acc & 15) == 15) ? 1 : 0; m_acc = (m_acc + 1) & 255; szp(m_acc); end
      5: begin m_ac = ((m_acc & 15) != 0) ? 1 : 0;  m_acc = (m_acc + 255) & 255; szp(m_acc); end
      6, 7, 8: begin
        if (op == 6) m_acc = m_acc & b;
        else if (op == 7) m_acc = m_acc | b;
        else m_acc = m_acc ^ b;
        m_ac = 0; m_cy = 0; szp(m_acc);
      end
      10: m_acc = (~m_acc) & 255;
      11: begin m_cy = m_acc >> 7; m_acc = ((m_acc << 1) | m_cy) & 255; end
      12: begin m_cy = m_acc & 1;  m_acc = (m_acc >> 1) | (m_cy << 7); end
      13: begin nb = m_acc >> 7; m_acc = ((m_acc << 1) | m_cy) & 255; m_cy = nb; end
      14: begin nb = m_acc & 1;  m_acc = (m_acc >> 1) | (m_cy << 7); m_cy = nb; end
      default: begin
        r = pa + pb;
        m_psum = r & 65535;
        m_cy = (r > 65535) ? 1 : 0;
      end
    endcase
  endtask

  task automatic compare(string tag);
    logic [4:0] ef;
    ef = {m_s[0], m_z[0], m_ac[0], m_p[0], m_cy[0]};
    n_vec++;
    if (acc_o !== m_acc[7:0] || flags_o !== ef || pair_sum_o !== m_psum[15:0]) begin
      n_fail++;
      $display("FAIL %s: acc=%02h flags=%05b psum=%04h, expected acc=%02h flags=%05b psum=%04h",
               tag, acc_o, flags_o, pair_sum_o, m_acc[7:0], ef, m_psum[15:0]);
    end
  endtask

  task automatic step(int op, int b, bit we = 1, int pa = 0, int pb = 0);
    @(negedge clk);
    op_i = op[3:0]; operand_i = b[7:0]; we_i = we;
    pair_a_i = pa[15:0]; pair_b_i = pb[15:0];
    if (we) model(op, b, pa, pb);
    @(posedge clk); #1;
    compare(tag_of(op, we));
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    m_acc = 0; m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0; m_psum = 0;
    rst_n = 1'b0; we_i = 1'b0; op_i = '0; operand_i = '0; pair_a_i = '0; pair_b_i = '0;
    repeat (3) @(posedge clk);
    #1 compare("R1");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 compare("R1");

    // R3/R5: nibble carry and byte wrap
    step(0, 8'h0F); step(1, 8'h01);
    step(0, 8'hFF); step(1, 8'h01);
    step(2, 8'h10);            // ADC with carry set
    step(2, 8'h7F);
    // R4: borrow, equality, compare
    step(0, 8'h10); step(3, 8'h01);
    step(3, 8'h0F); step(3, 8'h01);
    step(0, 8'h42); step(9, 8'h42); step(9, 8'h43);
    // R7: inc/dec around carry
    step(0, 8'hFF); step(1, 8'h01); step(4, 0); step(5, 0); step(5, 0);
    step(0, 8'h0F); step(4, 0);
    // R8
    step(0, 8'hF0); step(1, 8'hF0); step(6, 8'h3C); step(7, 8'h0F); step(8, 8'hFF);
    // R11
    step(9, 8'h80); step(10, 0); step(0, 8'hA5);
    // R9/R10: rotate chains
    step(11, 0); step(11, 0); step(12, 0); step(12, 0);
    step(13, 0); step(13, 0); step(14, 0); step(14, 0); step(14, 0);
    // R12
    step(15, 0, 1, 16'hFFFF, 16'h0001); step(15, 0, 1, 16'h1234, 16'h4321);
    // R2: idle cycles with live inputs
    step(1, 8'h55, 0); step(15, 0, 0, 16'h0100, 16'h0200); step(0, 8'h00, 0);

    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 15);
      step(op, $urandom_range(0, 255), ($urandom_range(0, 7) != 0),
           $urandom_range(0, 65535), $urandom_range(0, 65535));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule